// File: doc/BRIEF.md
# Rotating Shared Cell Buffer

This block is the output queue of a packet or cell switch port. In each clock cycle it can accept up to L cells, which arrive on L input lanes that are already compacted: the valid lanes always form a run that starts at lane 0. A rotation stage steers the lanes into L independent FIFOs. A write pointer decides where the cells go. Each cycle the pointer moves forward by the number of cells that arrived, modulo L. The next cycle's cells therefore start at the FIFO just after the last one written, and they wrap past FIFO L-1 back to FIFO 0.

A single reader visits the FIFOs in the same cyclic order and removes one cell per handshake. The L small FIFOs therefore behave as one queue with L inputs and one output, and cells leave in the order they arrived. Any FIFO can take any arrival, so no FIFO sits reserved for one lane.

The input side has no back-pressure. A cell whose target FIFO is already full at the start of the cycle is discarded and counted. The write pointer still moves past it, so the cyclic alignment between writer and reader is kept. The output is a valid/ready stream. While `out_valid` is high and `out_ready` is low, the presented cell is held unchanged. The block also reports how many cells it holds.

Top module: `shared_cell_buffer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `out_valid` is 0, `occupancy` is 0 and `drop_count` is 0. Both pointers start at FIFO 0.
- R2: In a cycle with n valid lanes, lane i (i < n) is written into FIFO (wp + i) mod L, where wp is the write pointer at the start of that cycle.
- R3: The input lanes are compacted. If lane i is invalid, then every lane above i is invalid too.
- R4: At the end of each cycle the write pointer advances by n mod L. This includes cells that were dropped.
- R5: `out_valid` is high exactly when the FIFO selected by the read pointer is non-empty, and `out_data` is that FIFO's oldest cell. When `out_valid` and `out_ready` are both high, that cell is removed and the read pointer moves to the next FIFO, mod L.
- R6: Each FIFO holds DEPTH cells. A cell aimed at a FIFO that holds DEPTH cells at the start of the cycle is dropped. This holds even if the same FIFO is read in that cycle.
- R7: After each clock edge, `occupancy` equals the total number of cells stored in the buffer.
- R8: `drop_count` increases by the number of cells dropped in each cycle. It wraps at 2^DCW.
- R9: When no cell is dropped, cells leave in arrival order. Within a cycle, the arrival order is lane order.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | LANES | Per-lane cell present, compacted from lane 0 |
| in_data | input | LANES*DW | Lane payloads, lane i at bits i*DW upward |
| out_valid | output | 1 | Output cell present |
| out_ready | input | 1 | Downstream accepts the output cell |
| out_data | output | DW | Output cell payload |
| occupancy | output | $clog2(LANES*DEPTH+1) | Cells currently stored |
| drop_count | output | DCW | Running count of discarded cells |

## Verification
The hardest case to reach from the ports is a full FIFO that receives a cell in the same cycle that the reader drains it, while its neighbours still have room. Only a write pointer that has wrapped unevenly across several bursts lines up that situation. The stimulus holds `out_ready` low for long random stretches while it pushes random arrival counts, which builds up uneven fill. A directed sequence then fills every FIFO and keeps pushing full bursts with `out_ready` high, so the reader pops one full FIFO while all its writes are discarded. Before that, a directed slot of three cells followed by four cells checks the wrap-around into FIFO 3 and back to FIFO 0.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  // Cyclic index step: (base + step) mod ring, for step <= ring.
  function automatic int unsigned ring_add(int unsigned base, int unsigned step,
                                           int unsigned ring);
    int unsigned s;
    s = base + step;
    if (s >= ring) s = s - ring;
    return s;
  endfunction
endpackage

// File: rtl/sbuf_lane_fifo.sv
module sbuf_lane_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rptr];

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= bump(wptr);
      if (do_pop)  rptr <= bump(rptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  // R6: a lane FIFO never holds more than DEPTH cells
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R6: a push into a full FIFO without a pop leaves it unchanged
  a_r6_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (full && $stable(wptr)));
endmodule

// File: rtl/sbuf_rotator.sv
module sbuf_rotator #(
  parameter int L  = 4,
  parameter int DW = 8,
  localparam int PW = (L > 1) ? $clog2(L) : 1
) (
  input  logic [L-1:0]    lane_valid,
  input  logic [L*DW-1:0] lane_data,
  input  logic [PW-1:0]   base,
  output logic [L-1:0]    fifo_we,
  output logic [L*DW-1:0] fifo_data
);
  import sbuf_pkg::*;

  for (genvar k = 0; k < L; k++) begin : g_tap
    logic [PW-1:0] src;
    // FIFO k receives lane (k - base) mod L
    always_comb begin
      src = PW'(ring_add(k, L - int'(base), L));
      fifo_we[k]              = lane_valid[src];
      fifo_data[k*DW +: DW]   = lane_data[int'(src)*DW +: DW];
    end
  end
endmodule

// File: rtl/shared_cell_buffer.sv
module shared_cell_buffer #(
  parameter int LANES = 4,
  parameter int DEPTH = 4,
  parameter int DW    = 8,
  parameter int DCW   = 16,
  localparam int PW = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int OW = $clog2(LANES * DEPTH + 1),
  localparam int FCW = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LANES-1:0]    in_valid,
  input  logic [LANES*DW-1:0] in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [DW-1:0]       out_data,
  output logic [OW-1:0]       occupancy,
  output logic [DCW-1:0]      drop_count
);
  import sbuf_pkg::*;

  logic [PW-1:0]         wr_ptr, rd_ptr;
  logic [LANES-1:0]      we, full, empty, pop, dropped;
  logic [LANES*DW-1:0]   wdata;
  logic [DW-1:0]         head [LANES];
  logic [FCW-1:0]        fcount [LANES];
  logic                  pop_fire;
  int unsigned           n_in, n_acc, n_drop;

  sbuf_rotator #(.L(LANES), .DW(DW)) u_rot (
    .lane_valid (in_valid),
    .lane_data  (in_data),
    .base       (wr_ptr),
    .fifo_we    (we),
    .fifo_data  (wdata)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_fifo
    assign pop[k]     = out_ready && (rd_ptr == PW'(k));
    assign dropped[k] = we[k] && full[k];
    sbuf_lane_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (we[k]),
      .push_data (wdata[k*DW +: DW]),
      .pop       (pop[k]),
      .head      (head[k]),
      .empty     (empty[k]),
      .full      (full[k]),
      .count     (fcount[k])
    );
  end

  always_comb begin
    n_in   = 0;
    n_drop = 0;
    for (int i = 0; i < LANES; i++) begin
      n_in   = n_in + int'(in_valid[i]);
      n_drop = n_drop + int'(dropped[i]);
    end
    n_acc = n_in - n_drop;
  end

  assign out_valid = !empty[rd_ptr];
  assign out_data  = head[rd_ptr];
  assign pop_fire  = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      occupancy  <= '0;
      drop_count <= '0;
    end else begin
      wr_ptr     <= PW'(ring_add(int'(wr_ptr), n_in, LANES));
      if (pop_fire) rd_ptr <= PW'(ring_add(int'(rd_ptr), 1, LANES));
      occupancy  <= occupancy + OW'(n_acc) - OW'(pop_fire);
      drop_count <= drop_count + DCW'(n_drop);
    end
  end

  // R3: valid lanes are compacted toward lane 0
  a_r3_compacted: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid & (in_valid + LANES'(1))) == '0);

  // R7: stored cells never exceed total capacity
  a_r7_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= OW'(LANES * DEPTH));

  // R5: a completed handshake moves the reader to another FIFO
  a_r5_reader_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_fire && LANES > 1) |=> (rd_ptr != $past(rd_ptr)));

  // R8: any discarded cell shows up in the drop counter
  a_r8_drop_counted: assert property (@(posedge clk) disable iff (!rst_n)
    (|dropped) |=> (drop_count != $past(drop_count)));

  // R10: a stalled output cell is held
  a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: tb/shared_cell_buffer_bench.sv
`timescale 1ns/1ps
module shared_cell_buffer_bench;
  localparam int L     = 4;
  localparam int DEPTH = 4;
  localparam int DW    = 8;
  localparam int DCW   = 16;
  localparam int OW    = $clog2(L * DEPTH + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [L-1:0]      in_valid = '0;
  logic [L*DW-1:0]   in_data = '0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic [DW-1:0]     out_data;
  logic [OW-1:0]     occupancy;
  logic [DCW-1:0]    drop_count;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [DW-1:0] mq [L][$];
  int mwr = 0, mrd = 0, mocc = 0, mdrops = 0;
  logic [DW-1:0] seq = '0;
  bit prev_stall = 0;
  logic [DW-1:0] prev_data = '0;

  always #4 clk = ~clk;

  shared_cell_buffer #(.LANES(L), .DEPTH(DEPTH), .DW(DW), .DCW(DCW)) u_shared_cell_buffer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .occupancy(occupancy), .drop_count(drop_count)
  );

  function automatic bit exp_valid();
    return mq[mrd].size() > 0;
  endfunction

  function automatic logic [L-1:0] thermo(int n);
    logic [L-1:0] v = '0;
    for (int i = 0; i < n; i++) v[i] = 1'b1;
    return v;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    chk(out_valid == exp_valid(), "R5 out_valid", int'(out_valid), int'(exp_valid()));
    if (exp_valid() && out_valid)
      chk(out_data == mq[mrd][0], "R2/R9 out_data order", int'(out_data), int'(mq[mrd][0]));
    chk(int'(occupancy) == mocc, "R7 occupancy", int'(occupancy), mocc);
    chk(int'(drop_count) == (mdrops % (1 << DCW)), "R8/R6 drop_count", int'(drop_count), mdrops);
    if (prev_stall)
      chk(out_valid && out_data == prev_data, "R10 stall hold", int'(out_data), int'(prev_data));
  endtask

  // one cycle: check state, drive n compacted cells (R3), update model at the edge
  task automatic cycle(int n, bit rdy);
    bit popping;
    @(negedge clk);
    check_outputs();
    in_valid = thermo(n);
    for (int i = 0; i < L; i++) begin
      in_data[i*DW +: DW] = seq + DW'(i);
    end
    out_ready = rdy;
    popping    = exp_valid() && rdy;
    prev_stall = exp_valid() && !rdy;
    prev_data  = exp_valid() ? mq[mrd][0] : '0;
    @(posedge clk);
    for (int i = 0; i < n; i++) begin
      int k = (mwr + i) % L;               // R2 target FIFO, R4 pointer
      if (mq[k].size() >= DEPTH) mdrops++; // R6 full at start of cycle
      else begin
        mq[k].push_back(seq + DW'(i));
        mocc++;
      end
    end
    if (popping) begin
      void'(mq[mrd].pop_front());
      mocc--;
      mrd = (mrd + 1) % L;
    end
    mwr = (mwr + n) % L;
    seq = seq + DW'(n);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned r;
    int rdy_pct;
    r = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    chk(occupancy == '0, "R1 occupancy in reset", int'(occupancy), 0);
    chk(drop_count == '0, "R1 drop_count in reset", int'(drop_count), 0);
    rst_n = 1'b1;

    // R2 R4 directed: 3 cells into FIFO 0..2, then 4 starting at FIFO 3 and wrapping
    cycle(3, 0);
    cycle(4, 0);
    cycle(0, 0);
    chk(int'(occupancy) == 7, "R3 compacted count stored", int'(occupancy), 7);
    repeat (8) cycle(0, 1); // R9 drain in arrival order

    // R6 fill everything, then overflow, then push into full FIFOs while popping
    repeat (4) cycle(4, 0);
    repeat (2) cycle(4, 0);
    repeat (3) cycle(4, 1);
    repeat (20) cycle(0, 1);
    chk(out_valid == 1'b0, "R5 empty after drain", int'(out_valid), 0);

    // random phases with varying back-pressure
    for (int ph = 0; ph < 20; ph++) begin
      rdy_pct = (ph % 3 == 0) ? 15 : ((ph % 3 == 1) ? 95 : 60);
      for (int c = 0; c < 250; c++) begin
        int n = $urandom_range(L, 0);
        if (ph % 3 == 1) n = $urandom_range(1, 0);
        cycle(n, ($urandom_range(99, 0) < rdy_pct));
      end
    end
    repeat (40) cycle(0, 1);
    @(negedge clk);
    check_outputs();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule